// File: doc/BRIEF.md
# Cascadable Timer/Counter with Compare Output and Capture

The block holds two 8-bit timer/counter channels. Each channel counts either ticks of its own prescaler, which divides the system clock by a selectable power of two, or rising edges of an external event input. In compare mode the count is checked against a data value on every counting tick. On a match the counter returns to zero, an interrupt pulse is raised, and the compare output pin can optionally toggle. The toggled pin gives a square wave with equal high and low times. In capture mode the compare is disabled and the counter runs and wraps freely. A rising edge on the capture input latches the running count and restarts the count from zero.

A level run input controls each channel. Its rising edge clears the counter, the prescaler and the compare pin, and starts counting. While run is low the channel holds its state. A cascade input joins the two channels into one 16-bit counter. In that mode channel 0 supplies the controls and channel 0 carries the results.

Top module: `tmr_top`

## Requirements
- R1: During and right after reset, irq, cmpOut and both capData bytes are all zero.
- R2: A rising run clears the channel's counter, prescaler and cmpOut. While run is low the count is frozen and no irq, toggle or capture occurs.
- R3: clkSel selects the counting tick as follows: 0 divides by 2, 1 by 4, 2 by 8, 3 by 32, 4 by 128, 5 by 512, 6 by 2048, and 7 selects external events. With a divide of D, the first increment falls D clocks after the start edge.
- R4: In compare mode a tick that finds count equal to cmpVal clears the count and raises irq for one cycle. Matches therefore repeat every (cmpVal+1)·D clocks, and a cmpVal of 0 gives a match on every tick.
- R5: When toggleEn is set, cmpOut inverts on every match. This gives a square wave with a period of 2·(cmpVal+1)·D clocks.
- R6: When clkSel is 7, each rising edge on evtIn counts once. The edge passes through a two-flop synchronizer, and the counter acts on it at the third clock edge after the input rises. The prescaler has no effect in this setting.
- R7: When capMode is set, a synchronized rising edge on capIn copies the count into capData, clears the count and the prescaler, and pulses irq. In this mode the compare is disabled and the counter wraps.
- R8: capData holds its value until the next capture.
- R9: When wide is set, the counter is {ch1,ch0}, a 16-bit value compared with {cmpVal[1],cmpVal[0]}. It uses channel 0's run, clkSel, capMode, toggleEn and inputs. Results appear on irq[0] and cmpOut[0], with capData[1] as the high byte and capData[0] as the low byte. irq[1] stays low.
- R10: In 8-bit mode the two channels are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide | input | 1 | Cascade both channels into 16 bits |
| run | input | 2 | Per channel: run level, rising edge clears and starts |
| clkSel | input | 2x3 | Per channel: tick select |
| capMode | input | 2 | Per channel: capture mode |
| toggleEn | input | 2 | Per channel: toggle cmpOut on match |
| cmpVal | input | 2xCW | Per channel: compare value |
| evtIn | input | 2 | Per channel: external event clock |
| capIn | input | 2 | Per channel: capture edge input |
| cmpOut | output | 2 | Per channel: compare output pin |
| capData | output | 2xCW | Per channel: captured count |
| irq | output | 2 | Per channel: one-cycle interrupt pulse |

## Verification
Every result is registered and becomes visible one clock edge after the edge that decides it. The first irq therefore follows the start edge by (cmpVal+1)·D+1 edges. A capture or event edge shows up three edges after the pin changes. The bench drives inputs on falling edges and counts falling edges from the drive point. It compares each result at exactly the predicted count and also one count before it, so an off-by-one in either direction is caught. Capture values are checked against floor((n+1)/D), where n is the count of falling edges since the start.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH = 2;
  localparam int PRESC_W = 11;
  localparam logic [2:0] SEL_EVENT = 3'd7;

  typedef struct packed {
    logic clr;
    logic inc;
    logic cap;
  } tmr_strobe_t;

  function automatic int unsigned presc_shift(input logic [2:0] sel);
    case (sel)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 5;
      3'd4: return 7;
      3'd5: return 9;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [2:0]  clkSel,
  input  logic        capMode,
  input  logic        evtIn,
  input  logic        capIn,
  output tmr_strobe_t stb
);
  localparam logic [PRESC_W-1:0] P_ONE = 1;

  logic [2:0] evtSync, capSync;
  logic runQ;
  logic [PRESC_W-1:0] presc, prescMask;
  logic startStb, evtRise, capRise, tick;
  logic [3:0] shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evtSync <= '0;
      capSync <= '0;
      runQ    <= 1'b0;
    end else begin
      evtSync <= {evtSync[1:0], evtIn};
      capSync <= {capSync[1:0], capIn};
      runQ    <= run;
    end
  end

  assign evtRise  = evtSync[1] & ~evtSync[2];
  assign capRise  = capSync[1] & ~capSync[2];
  assign startStb = run & ~runQ;
  assign shamt    = 4'(presc_shift(clkSel));

  always_comb begin
    for (int i = 0; i < PRESC_W; i++) prescMask[i] = (i < int'(shamt));
  end

  assign tick = (clkSel == SEL_EVENT) ? evtRise : ((presc & prescMask) == prescMask);

  always_comb begin
    stb.clr = startStb;
    stb.cap = run & ~startStb & capMode & capRise;
    stb.inc = run & ~startStb & ~stb.cap & tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              presc <= '0;
    else if (!run || startStb || stb.cap)    presc <= '0;
    else                                     presc <= presc + P_ONE;
  end

  // R3: divide-by-2 ticks never arrive on consecutive cycles
  a_r3_div2_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.inc && clkSel == 3'd0) |=> !stb.inc);

  // R7: a capture strobe comes only from an input that was high two samples earlier
  a_r7_cap_synced: assert property (@(posedge clk) disable iff (!rst_n)
    stb.cap |-> $past(capIn, 2));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wide,
  input  tmr_strobe_t [NCH-1:0]      stb,
  input  logic [NCH-1:0]             capMode,
  input  logic [NCH-1:0]             toggleEn,
  input  logic [NCH-1:0][CW-1:0]     cmpVal,
  output logic [NCH-1:0]             cmpOut,
  output logic [NCH-1:0][CW-1:0]     capData,
  output logic [NCH-1:0]             irq
);
  localparam int WW = 2 * CW;
  localparam logic [CW-1:0] C_ONE = 1;
  localparam logic [WW-1:0] W_ONE = 1;

  logic [NCH-1:0][CW-1:0] cnt, cntNx, capNx;
  logic [NCH-1:0] outNx, irqNx;
  logic [WW-1:0] wCnt, wCmp;

  assign wCnt = {cnt[1], cnt[0]};
  assign wCmp = {cmpVal[1], cmpVal[0]};

  always_comb begin
    cntNx = cnt;
    capNx = capData;
    outNx = cmpOut;
    irqNx = '0;
    if (wide) begin
      if (stb[0].clr) begin
        cntNx    = '0;
        outNx[0] = 1'b0;
      end else if (stb[0].cap) begin
        {capNx[1], capNx[0]} = wCnt;
        cntNx    = '0;
        irqNx[0] = 1'b1;
      end else if (stb[0].inc) begin
        if (!capMode[0] && wCnt == wCmp) begin
          cntNx    = '0;
          irqNx[0] = 1'b1;
          if (toggleEn[0]) outNx[0] = ~cmpOut[0];
        end else begin
          {cntNx[1], cntNx[0]} = wCnt + W_ONE;
        end
      end
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (stb[ch].clr) begin
          cntNx[ch] = '0;
          outNx[ch] = 1'b0;
        end else if (stb[ch].cap) begin
          capNx[ch] = cnt[ch];
          cntNx[ch] = '0;
          irqNx[ch] = 1'b1;
        end else if (stb[ch].inc) begin
          if (!capMode[ch] && cnt[ch] == cmpVal[ch]) begin
            cntNx[ch] = '0;
            irqNx[ch] = 1'b1;
            if (toggleEn[ch]) outNx[ch] = ~cmpOut[ch];
          end else begin
            cntNx[ch] = cnt[ch] + C_ONE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      capData <= '0;
      cmpOut  <= '0;
      irq     <= '0;
    end else begin
      cnt     <= cntNx;
      capData <= capNx;
      cmpOut  <= outNx;
      irq     <= irqNx;
    end
  end

  // R4: a match on a counting tick in compare mode raises irq next cycle
  a_r4_match_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && stb[0].inc && !capMode[0] && cnt[0] == cmpVal[0]) |=> (irq[0] && cnt[0] == '0));

  // R7: a capture restarts the count from zero
  a_r7_cap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && stb[0].cap) |=> cnt[0] == '0);

  // R8: captured data moves only on a capture strobe
  a_r8_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb[0].cap && !stb[1].cap) |=> $stable(capData));

  // R9: the upper channel stays quiet while cascaded
  a_r9_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !irq[1]);
endmodule

// File: rtl/tmr_top.sv
module tmr_top #(
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wide,
  input  logic [1:0]           run,
  input  logic [1:0][2:0]      clkSel,
  input  logic [1:0]           capMode,
  input  logic [1:0]           toggleEn,
  input  logic [1:0][CW-1:0]   cmpVal,
  input  logic [1:0]           evtIn,
  input  logic [1:0]           capIn,
  output logic [1:0]           cmpOut,
  output logic [1:0][CW-1:0]   capData,
  output logic [1:0]           irq
);
  import tmr_pkg::*;

  tmr_strobe_t [NCH-1:0] stb;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    tmr_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run[ch]),
      .clkSel  (clkSel[ch]),
      .capMode (capMode[ch]),
      .evtIn   (evtIn[ch]),
      .capIn   (capIn[ch]),
      .stb     (stb[ch])
    );
  end

  tmr_datapath #(.CW(CW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide     (wide),
    .stb      (stb),
    .capMode  (capMode),
    .toggleEn (toggleEn),
    .cmpVal   (cmpVal),
    .cmpOut   (cmpOut),
    .capData  (capData),
    .irq      (irq)
  );
endmodule

// File: tb/tb_tmr_top.sv
`timescale 1ns/100ps
module tb_tmr_top;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide = 1'b0;
  logic [1:0] run = '0;
  logic [1:0][2:0] clkSel = '0;
  logic [1:0] capMode = '0;
  logic [1:0] toggleEn = '0;
  logic [1:0][CW-1:0] cmpVal = '0;
  logic [1:0] evtIn = '0;
  logic [1:0] capIn = '0;
  logic [1:0] cmpOut;
  logic [1:0][CW-1:0] capData;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr_top #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wide(wide), .run(run), .clkSel(clkSel),
    .capMode(capMode), .toggleEn(toggleEn), .cmpVal(cmpVal),
    .evtIn(evtIn), .capIn(capIn), .cmpOut(cmpOut), .capData(capData), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int divOf(input logic [2:0] sel);
    case (sel)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 32;
      3'd4: return 128;
      3'd5: return 512;
      default: return 2048;
    endcase
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stopAll();
    run = '0; capIn = '0; evtIn = '0; capMode = '0; toggleEn = '0; wide = 1'b0;
    idle(5);
  endtask

  // R1
  task automatic t_reset();
    chk("R1", "irq in reset", irq, 0);
    chk("R1", "cmpOut in reset", cmpOut, 0);
    chk("R1", "capData in reset", capData, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1", "irq after reset", irq, 0);
  endtask

  // R3 R4 R10: first and second match times on one channel
  task automatic t_match(input int ch, input logic [2:0] sel, input int n);
    int period, first, second, hits, other;
    period = (n + 1) * divOf(sel);
    first = 0; second = 0; hits = 0; other = 0;
    clkSel[ch] = sel; cmpVal[ch] = CW'(n); run[ch] = 1'b1;
    for (int k = 1; k <= 2 * period + 1; k++) begin
      @(negedge clk);
      if (irq[ch]) begin
        hits++;
        if (first == 0) first = k; else if (second == 0) second = k;
      end
      if (irq[1-ch]) other++;
    end
    chk("R4", $sformatf("ch%0d sel%0d first irq", ch, sel), first, period + 1);
    chk("R3", $sformatf("ch%0d sel%0d second irq", ch, sel), second, 2 * period + 1);
    chk("R4", "irq pulse count", hits, 2);
    chk("R10", "other channel quiet", other, 0);
    run[ch] = 1'b0;
    idle(4);
  endtask

  // R5 R2
  task automatic t_toggle();
    int quietIrq;
    clkSel[0] = 3'd0; cmpVal[0] = 8'd2; toggleEn[0] = 1'b1; run[0] = 1'b1;
    idle(6);
    chk("R5", "cmpOut before match", cmpOut[0], 0);
    idle(1);
    chk("R5", "cmpOut after first match", cmpOut[0], 1);
    idle(6);
    chk("R5", "cmpOut after second match", cmpOut[0], 0);
    idle(6);
    chk("R5", "cmpOut after third match", cmpOut[0], 1);
    run[0] = 1'b0;
    quietIrq = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (irq[0] || !cmpOut[0]) quietIrq++;
    end
    chk("R2", "stopped channel frozen", quietIrq, 0);
    run[0] = 1'b1;
    idle(1);
    chk("R2", "start clears cmpOut", cmpOut[0], 0);
    idle(6);
    chk("R2", "restart match time", cmpOut[0], 1);
    stopAll();
  endtask

  // R6
  task automatic t_event();
    clkSel[1] = 3'd7; cmpVal[1] = 8'd2; run[1] = 1'b1;
    idle(3);
    for (int p = 1; p <= 3; p++) begin
      evtIn[1] = 1'b1;
      idle(2);
      evtIn[1] = 1'b0;
      idle(1);
      chk("R6", $sformatf("irq after event %0d", p), irq[1], (p == 3) ? 1 : 0);
      idle(1);
    end
    chk("R6", "irq pulse ends", irq[1], 0);
    chk("R10", "ch0 quiet during events", irq[0], 0);
    stopAll();
  endtask

  // R7 R8
  task automatic t_capture();
    capMode[0] = 1'b1; clkSel[0] = 3'd1; cmpVal[0] = 8'd3; run[0] = 1'b1;
    idle(40);
    capIn[0] = 1'b1;
    idle(2);
    chk("R7", "capData before capture edge", capData[0], 0);
    chk("R7", "irq before capture edge", irq[0], 0);
    idle(1);
    chk("R7", "captured count", capData[0], 10);
    chk("R7", "capture irq", irq[0], 1);
    idle(1);
    capIn[0] = 1'b0;
    chk("R7", "capture irq one cycle", irq[0], 0);
    idle(16);
    capIn[0] = 1'b1;
    idle(2);
    chk("R8", "capData held", capData[0], 10);
    idle(1);
    chk("R7", "second capture after restart", capData[0], 4);
    chk("R10", "ch1 capData untouched", capData[1], 0);
    stopAll();
  endtask

  // R9
  task automatic t_wide();
    int first, hiIrq, at91;
    wide = 1'b1; clkSel[0] = 3'd0; cmpVal[0] = 8'd44; cmpVal[1] = 8'd1;
    clkSel[1] = 3'd0; run[1] = 1'b0; run[0] = 1'b1;
    first = 0; hiIrq = 0; at91 = 0;
    for (int k = 1; k <= 605; k++) begin
      @(negedge clk);
      if (irq[0] && first == 0) first = k;
      if (irq[1]) hiIrq++;
      if (k == 91) at91 = irq[0];
    end
    chk("R9", "16-bit match time", first, 603);
    chk("R9", "no 8-bit match", at91, 0);
    chk("R9", "irq[1] quiet", hiIrq, 0);
    run[0] = 1'b0;
    idle(3);
    capMode[0] = 1'b1; run[0] = 1'b1;
    idle(599);
    capIn[0] = 1'b1;
    idle(3);
    chk("R9", "wide capture high byte", capData[1], 1);
    chk("R9", "wide capture low byte", capData[0], 44);
    stopAll();
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    t_match(0, 3'd0, 5);
    t_match(0, 3'd3, 3);
    t_match(1, 3'd1, 0);
    t_match(1, 3'd6, 1);
    t_toggle();
    t_event();
    t_capture();
    t_wide();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule